// File: doc/BRIEF.md
# Frequency-Shift-Keyed Tag Identifier Demodulator

This block sits behind a low-frequency reader front end and turns a stream of peak-detected 8-bit amplitude samples into a 44-bit tag identifier. Each accepted sample is compared against a fixed level to give one logic bit. The block waits for the first low-to-high change of that bit, then measures the number of samples from each rising edge to the next. Short periods are counted as the fast subcarrier and long periods as the slow subcarrier. The fast subcarrier carries a half-bit of level 1 and the slow one a half-bit of level 0.

Successive cycles of the same class are grouped into runs. A rounded division turns each run length into a number of Manchester half-bits. A frame decoder then looks for the start-of-frame half-bit pattern, turns the half-bit pairs that follow into identifier bits, and reports the accumulated identifier when the next start-of-frame pattern arrives. The identifier comes out as a 12-bit upper part and a 32-bit lower part, with a one-cycle strobe. A single-shot input stops decoding after the first identifier.

Top module: `fsk_id_demod`

## Requirements
- R1: A sample is taken as logic 1 when its value is 127 or more, and as logic 0 when it is 126 or less. Only samples presented with `sample_valid` high are used.
- R2: No cycle is measured before the first 0-to-1 change of the sliced stream. After that, each later 0-to-1 change ends one measured cycle, whose length is the number of accepted samples since the previous 0-to-1 change.
- R3: A measured cycle shorter than 9 samples is the fast class (level 1). A cycle of 9 samples or more is the slow class (level 0). Periods of 7 to 8 and 9 to 11 samples therefore decode the same as 8 and 10.
- R4: A run of n consecutive fast cycles gives floor((n+1)/6) half-bits of level 1. A run of n consecutive slow cycles gives floor((n+1)/5) half-bits of level 0. A run is closed when a cycle of the other class arrives.
- R5: A run that gives 1, 2, 3 or 4 half-bits emits exactly that many. A run that gives 0 or 5 or more emits nothing, so a lone fast cycle between slow runs, or a slow run of 25 cycles, leaves the decoded identifier unchanged.
- R6: The half-bit sequence 1,1,1,0,0,0 in time order marks start of frame. After it, the pair 0,1 decodes to identifier bit 1 and the pair 1,0 decodes to bit 0. Bits shift in most significant first.
- R7: At each start-of-frame marker seen while a frame is open, a nonzero accumulated identifier is reported and the accumulator is cleared. An identifier of zero is not reported.
- R8: A half-bit pair 0,0 or 1,1 that is not part of a start-of-frame marker ends the open frame and clears its bits. Decoding then waits for the next marker, and the bits of the aborted frame are never reported.
- R9: A report sets `id_hi` to identifier bits 43..32 and `id_lo` to bits 31..0, and raises `id_valid` for exactly one clock. Both outputs hold their value between reports.
- R10: When `find_one` is high, no report follows the first one until reset.
- R11: While `rst` is high and in the cycle after it is released, `id_valid`, `id_hi` and `id_lo` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Qualifies `sample` for this clock |
| sample | input | 8 | Peak-detected amplitude sample |
| find_one | input | 1 | Stop after the first reported identifier |
| id_hi | output | 12 | Upper identifier bits 43..32 |
| id_lo | output | 32 | Lower identifier bits 31..0 |
| id_valid | output | 1 | One-cycle strobe for a new identifier |

## Verification
The bench builds the block with its default parameters: an 8-bit sample, a slicing level of 127, a class split at 9, a 6-bit period counter, a 5-bit run counter and a 44-bit identifier. It builds waveforms from half-bit sequences, so every run length from 1 to 4 half-bits of both levels shows up where markers and data pairs meet. The defaults also bring the rejected run lengths within reach (a single stray fast cycle and a 25-cycle slow run), along with jittered periods of 7, 9 and 11 samples, samples exactly at 126 and 127, and identifiers that reach both ends of the 44-bit word.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;
  // largest number of half-bits one run may emit
  localparam int HB_MAX   = 4;
  localparam int HB_CNT_W = $clog2(HB_MAX + 1);
  // start-of-frame half-bits, oldest in the MSB
  localparam logic [5:0] SOF_PATTERN = 6'b111000;

  typedef enum logic {ST_HUNT, ST_FRAME} frm_state_e;
endpackage

// File: rtl/fsk_edge_classifier.sv
module fsk_edge_classifier
  import fsk_demod_pkg::*;
#(
  parameter int SAMP_W      = 8,
  parameter int SLICE_LEVEL = 127,
  parameter int SPLIT       = 9,
  parameter int PER_W       = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [SAMP_W-1:0] smp,
  output logic              cyc_vld,
  output logic              cyc_is10
);
  localparam logic [PER_W-1:0] PER_MAX = '1;

  logic             bit_now;
  logic             prev_bit;
  logic             synced;
  logic [PER_W-1:0] per_cnt;
  logic             rise;

  assign bit_now = (smp >= SAMP_W'(SLICE_LEVEL));
  assign rise    = bit_now & ~prev_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_bit <= 1'b1;   // first sample can never be an edge
      synced   <= 1'b0;
      per_cnt  <= '0;
      cyc_vld  <= 1'b0;
      cyc_is10 <= 1'b0;
    end else begin
      cyc_vld <= 1'b0;
      if (smp_vld) begin
        prev_bit <= bit_now;
        if (rise) begin
          synced  <= 1'b1;
          per_cnt <= PER_W'(1);
          if (synced) begin
            cyc_vld  <= 1'b1;
            cyc_is10 <= (per_cnt >= PER_W'(SPLIT));
          end
        end else if (per_cnt != PER_MAX) begin
          per_cnt <= per_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsk_run_decoder.sv
module fsk_run_decoder
  import fsk_demod_pkg::*;
#(
  parameter int RUN_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cyc_vld,
  input  logic                cyc_is10,
  output logic [HB_CNT_W-1:0] hb_cnt,
  output logic                hb_lvl
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic             run_live;
  logic             run_is10;
  logic [RUN_W-1:0] run_len;
  logic [RUN_W:0]   len_p1;
  logic [RUN_W:0]   half_n;
  logic [HB_CNT_W-1:0] emit_n;

  assign len_p1 = {1'b0, run_len} + 1'b1;
  assign half_n = run_is10 ? (len_p1 / (RUN_W+1)'(5)) : (len_p1 / (RUN_W+1)'(6));

  always_comb begin
    if (half_n >= (RUN_W+1)'(1) && half_n <= (RUN_W+1)'(HB_MAX))
      emit_n = HB_CNT_W'(half_n);
    else
      emit_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_live <= 1'b0;
      run_is10 <= 1'b0;
      run_len  <= '0;
      hb_cnt   <= '0;
      hb_lvl   <= 1'b0;
    end else begin
      hb_cnt <= '0;
      if (cyc_vld) begin
        if (!run_live) begin
          run_live <= 1'b1;
          run_is10 <= cyc_is10;
          run_len  <= RUN_W'(1);
        end else if (cyc_is10 == run_is10) begin
          if (run_len != RUN_MAX) run_len <= run_len + 1'b1;
        end else begin
          hb_cnt   <= emit_n;
          hb_lvl   <= ~run_is10;
          run_is10 <= cyc_is10;
          run_len  <= RUN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fsk_frame_decoder.sv
module fsk_frame_decoder
  import fsk_demod_pkg::*;
#(
  parameter int ID_W = 44,
  parameter int HI_W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 find_one,
  input  logic [HB_CNT_W-1:0]  hb_cnt,
  input  logic                 hb_lvl,
  output logic [HI_W-1:0]      id_hi,
  output logic [ID_W-HI_W-1:0] id_lo,
  output logic                 id_valid
);
  localparam int LO_W = ID_W - HI_W;

  frm_state_e      st, n_st;
  logic [5:0]      hist, n_hist;
  logic [2:0]      fill, n_fill;
  logic [ID_W-1:0] acc, n_acc, rep_val;
  logic            rep;
  logic            done;

  // up to HB_MAX half-bits are folded in per clock
  always_comb begin
    n_st    = st;
    n_hist  = hist;
    n_fill  = fill;
    n_acc   = acc;
    rep     = 1'b0;
    rep_val = acc;
    for (int k = 0; k < HB_MAX; k++) begin
      if (!done && (HB_CNT_W'(k) < hb_cnt)) begin
        n_hist = {n_hist[4:0], hb_lvl};
        if (n_st == ST_HUNT) begin
          if (n_hist == SOF_PATTERN) begin
            n_st   = ST_FRAME;
            n_fill = '0;
            n_acc  = '0;
          end
        end else begin
          n_fill = n_fill + 1'b1;
          if (n_fill == 3'd6) begin
            if (n_hist == SOF_PATTERN) begin
              if (|n_acc) begin
                rep     = 1'b1;
                rep_val = n_acc;
              end
              n_acc  = '0;
              n_fill = '0;
            end else if (n_hist[5:4] == 2'b01) begin
              n_acc  = {n_acc[ID_W-2:0], 1'b1};
              n_fill = 3'd4;
            end else if (n_hist[5:4] == 2'b10) begin
              n_acc  = {n_acc[ID_W-2:0], 1'b0};
              n_fill = 3'd4;
            end else begin
              n_st   = ST_HUNT;
              n_acc  = '0;
              n_fill = '0;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_HUNT;
      hist     <= '0;
      fill     <= '0;
      acc      <= '0;
      done     <= 1'b0;
      id_valid <= 1'b0;
      id_hi    <= '0;
      id_lo    <= '0;
    end else begin
      st       <= n_st;
      hist     <= n_hist;
      fill     <= n_fill;
      acc      <= n_acc;
      id_valid <= rep;
      if (rep) begin
        id_hi <= rep_val[ID_W-1 -: HI_W];
        id_lo <= rep_val[LO_W-1:0];
        if (find_one) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsk_id_demod.sv
module fsk_id_demod
  import fsk_demod_pkg::*;
#(
  parameter int SAMP_W      = 8,
  parameter int SLICE_LEVEL = 127,
  parameter int SPLIT       = 9,
  parameter int PER_W       = 6,
  parameter int RUN_W       = 5,
  parameter int ID_W        = 44,
  parameter int HI_W        = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_valid,
  input  logic [SAMP_W-1:0]    sample,
  input  logic                 find_one,
  output logic [HI_W-1:0]      id_hi,
  output logic [ID_W-HI_W-1:0] id_lo,
  output logic                 id_valid
);
  logic                cyc_vld;
  logic                cyc_is10;
  logic [HB_CNT_W-1:0] hb_cnt;
  logic                hb_lvl;

  fsk_edge_classifier #(
    .SAMP_W(SAMP_W), .SLICE_LEVEL(SLICE_LEVEL), .SPLIT(SPLIT), .PER_W(PER_W)
  ) u_edge (
    .clk(clk), .rst(rst), .smp_vld(sample_valid), .smp(sample),
    .cyc_vld(cyc_vld), .cyc_is10(cyc_is10)
  );

  fsk_run_decoder #(.RUN_W(RUN_W)) u_run (
    .clk(clk), .rst(rst), .cyc_vld(cyc_vld), .cyc_is10(cyc_is10),
    .hb_cnt(hb_cnt), .hb_lvl(hb_lvl)
  );

  fsk_frame_decoder #(.ID_W(ID_W), .HI_W(HI_W)) u_frame (
    .clk(clk), .rst(rst), .find_one(find_one), .hb_cnt(hb_cnt), .hb_lvl(hb_lvl),
    .id_hi(id_hi), .id_lo(id_lo), .id_valid(id_valid)
  );
endmodule

// File: rtl/fsk_id_demod_chk.sv
module fsk_id_demod_chk #(
  parameter int HI_W  = 12,
  parameter int LO_W  = 32,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_valid,
  input logic             find_one,
  input logic             cyc_vld,
  input logic [CNT_W-1:0] hb_cnt,
  input logic [HI_W-1:0]  id_hi,
  input logic [LO_W-1:0]  id_lo,
  input logic             id_valid
);
  logic got_one;

  always_ff @(posedge clk) begin
    if (rst) got_one <= 1'b0;
    else if (id_valid && find_one) got_one <= 1'b1;
  end

  AST_CYCLE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    cyc_vld |-> $past(sample_valid)); // R2

  AST_RUN_EMIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    hb_cnt <= CNT_W'(4)); // R5

  AST_ID_NONZERO: assert property (@(posedge clk) disable iff (rst)
    id_valid |-> (|{id_hi, id_lo})); // R7

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    id_valid |=> !id_valid); // R9

  AST_ID_HELD: assert property (@(posedge clk) disable iff (rst)
    !id_valid |-> $stable({id_hi, id_lo})); // R9

  AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (find_one && got_one) |-> !id_valid); // R10
endmodule

bind fsk_id_demod fsk_id_demod_chk #(
  .HI_W(HI_W), .LO_W(ID_W - HI_W), .CNT_W(fsk_demod_pkg::HB_CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .sample_valid(sample_valid), .find_one(find_one),
  .cyc_vld(cyc_vld), .hb_cnt(hb_cnt), .id_hi(id_hi), .id_lo(id_lo),
  .id_valid(id_valid)
);

// File: tb/sim_fsk_id_demod.sv
module sim_fsk_id_demod;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_valid = 1'b0;
  logic [7:0]  sample = '0;
  logic        find_one = 1'b0;
  logic [11:0] id_hi;
  logic [31:0] id_lo;
  logic        id_valid;

  int n_tests = 0;
  int n_fail  = 0;
  int got_cnt = 0;
  int jit_idx = 0;
  bit gap_mode = 0;
  bit jitter   = 0;
  bit mon_en   = 0;
  bit prev_vld = 0;
  logic [7:0]  hi_lv = 8'd200;
  logic [7:0]  lo_lv = 8'd20;
  logic [43:0] exp_q[$];

  always #2.5 clk = ~clk;

  fsk_id_demod u0 (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample(sample),
    .find_one(find_one), .id_hi(id_hi), .id_lo(id_lo), .id_valid(id_valid)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // monitor, sampling outputs away from the active edge
  always @(negedge clk) begin
    if (mon_en) begin
      if (id_valid) begin
        got_cnt++;
        check(!prev_vld, "R9 strobe one cycle", 64'(prev_vld), 64'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected report", {20'd0, id_hi, id_lo}, 64'd0);
        end else begin
          logic [43:0] e;
          e = exp_q.pop_front();
          check({id_hi, id_lo} == e, "R4 R6 R9 reported id", {20'd0, id_hi, id_lo}, {20'd0, e});
        end
      end
      prev_vld = id_valid;
    end
  end

  task automatic put(input logic [7:0] v);
    @(negedge clk); #1;
    sample = v; sample_valid = 1'b1;
    if (gap_mode) begin
      @(negedge clk); #1;
      sample_valid = 1'b0;
    end
  endtask

  task automatic cyc(input bit is10);
    int per;
    int hl;
    if (is10) per = jitter ? 9 + (jit_idx % 3) : 10;
    else      per = jitter ? 7 + (jit_idx % 2) : 8;
    hl = is10 ? 3 : 2;
    jit_idx++;
    for (int i = 0; i < per; i++) put(i < hl ? hi_lv : lo_lv);
  endtask

  task automatic half(input bit lvl);
    if (lvl) repeat (6) cyc(1'b0);
    else     repeat (5) cyc(1'b1);
  endtask

  task automatic sof();
    half(1); half(1); half(1); half(0); half(0); half(0);
  endtask

  task automatic pair(input bit b);
    if (b) begin half(0); half(1); end
    else   begin half(1); half(0); end
  endtask

  // ins_fc8: lone fast cycle before every group of four bits (R5)
  // long_at: bit after which a 25-cycle slow run is inserted (R5)
  task automatic send_id(input logic [43:0] id, input bit ins_fc8, input int long_at);
    for (int i = 43; i >= 0; i--) begin
      if (ins_fc8 && (i % 4) == 3) cyc(1'b0);
      pair(id[i]);
      if (i == long_at) repeat (25) cyc(1'b1);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk); #1;
    sample_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_reset_outputs(input string tag);
    check(id_valid == 1'b0, tag, 64'(id_valid), 64'd0);
    check(id_hi == '0, tag, 64'(id_hi), 64'd0);
    check(id_lo == '0, tag, 64'(id_lo), 64'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check_reset_outputs("R11 in reset");
    #1 rst = 1'b0;
    @(negedge clk);
    check_reset_outputs("R11 after release");
    mon_en = 1;

    // session 1: continuous decoding
    for (int i = 0; i < 5; i++) put(lo_lv);
    sof();
    send_id(44'h123_4567_89AB, 0, -1);              // R4 R6
    exp_q.push_back(44'h123_4567_89AB);
    sof();
    jitter = 1;                                       // R3 periods 7,8 and 9,10,11
    send_id(44'hEDC_BA98_7654, 0, -1);
    exp_q.push_back(44'hEDC_BA98_7654);
    jitter = 0;
    sof();
    // R8: ten valid bits, then an invalid 0,0 pair, then more bits
    for (int i = 9; i >= 0; i--) pair(10'h2B5 >> i);
    half(0); half(0);
    for (int i = 0; i < 20; i++) pair(i[0]);
    sof();                                            // found while hunting
    send_id(44'hA5A_5A5A_5A5A, 1, 43);                // R5 ignored runs
    exp_q.push_back(44'hA5A_5A5A_5A5A);
    sof();
    send_id(44'h000_0000_0000, 0, -1);                // R7 zero id not reported
    sof();
    hi_lv = 8'd127; lo_lv = 8'd126;                   // R1 slicing boundary
    send_id(44'h001_0000_0001, 0, -1);
    exp_q.push_back(44'h001_0000_0001);
    sof();
    half(1); half(0); half(1);
    hi_lv = 8'd200; lo_lv = 8'd20;
    idle(20);
    check(got_cnt == 4, "R7 R8 report count", 64'(got_cnt), 64'd4);
    check(exp_q.size() == 0, "R6 all expected ids seen", 64'(exp_q.size()), 64'd0);

    // session 2: single shot, gapped sample_valid
    mon_en = 0;
    @(negedge clk); #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    find_one = 1'b1;
    @(negedge clk);
    check_reset_outputs("R11 second reset");
    mon_en = 1; got_cnt = 0; prev_vld = 0;
    gap_mode = 1;                                     // R2 samples only on sample_valid
    for (int i = 0; i < 3; i++) put(lo_lv);
    sof();
    send_id(44'hFFF_FFFF_FFFF, 0, -1);
    exp_q.push_back(44'hFFF_FFFF_FFFF);
    sof();
    send_id(44'h800_0000_0000, 0, -1);
    sof();
    half(1); half(0); half(1);
    gap_mode = 0;
    idle(20);
    check(got_cnt == 1, "R10 single report", 64'(got_cnt), 64'd1);
    check(id_hi == 12'hFFF && id_lo == 32'hFFFF_FFFF, "R10 R9 first id held",
          {20'd0, id_hi, id_lo}, 64'hFFF_FFFF_FFFF);
    check(exp_q.size() == 0, "R2 gapped id seen", 64'(exp_q.size()), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule